// File: doc/BRIEF.md
# SPI Register File with Indirect Window

This block is the SPI slave front end of a radio transceiver's control registers. A host processor reaches two byte-wide storage spaces over one SPI link. The first is a flat direct space of 64 locations. The second is an indirect space of 256 locations, reached through one reserved direct address that acts as a window. The SPI pins are sampled with the block's own system clock. The SPI clock must therefore be slower than about one sixth of the system clock.

Every transaction opens with a header byte. Bit 7 of the header selects the direction, where 1 means read. Bit 6 selects register space when it is 0, and the packet buffer when it is 1. Bits 5..0 hold the direct address. When the direct address equals the window (0x3E), the next byte is an 8-bit indirect index, and the bytes after it are data. Any other direct address is followed directly by data. In both spaces every further byte in the same chip-select window moves to the next location.

Read data leaves on MISO in SPI mode 0, most significant bit first. MISO is driven only while chip select is low. Bytes are committed only when complete, so a transfer cut short never stores a fragment.

Top module: `spi_regfile`

## Requirements
- R1: After reset every direct and indirect location reads as 0x00, and MISO is 0 during every header byte.
- R2: A header with bit 7 = 0, bit 6 = 0 and a direct address A (bits 5..0, A not 0x3E), followed by one data byte, stores that byte at direct location A.
- R3: A header with bit 7 = 1, bit 6 = 0 and direct address A makes the slave shift location A out on MISO, MSB first, during the byte after the header. Bits change on SCK falling edges and are sampled by the host on rising edges.
- R4: In a direct burst the address rises by one per data byte and wraps from 0x3F to 0x00. The window location 0x3E, when passed in a burst, ignores written bytes and reads as 0x00.
- R5: A header with direct address 0x3E and bit 7 = 0, followed by index I and a data byte, stores the data byte at indirect location I.
- R6: A header with direct address 0x3E and bit 7 = 1 returns 0x00 during the index byte, then returns indirect location I during the next byte.
- R7: In an indirect burst the index rises by one per data byte and wraps from 0xFF to 0x00.
- R8: A header with bit 6 = 1 reaches no register. Nothing is written, and MISO returns 0x00 for every byte of that transaction.
- R9: Raising chip select at any point ends the transaction. A partly shifted byte is discarded, and the next transaction starts with a fresh header.
- R10: The MISO output enable is high exactly while chip select is low.
- R11: Direct location 0x3B, the version slot, returns the last value written to it, and each later write replaces that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also oversamples the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | SPI serial clock, mode 0 |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | High while MISO should be driven onto the pad |

## Verification
A wrong transaction phase or a stale pointer shows up within one byte. It appears either as a wrong byte on MISO during a read burst, or as a changed location that a later read-back exposes. A wrong bit counter shifts the byte boundary, so the first read byte after the header arrives rotated. A missing reset of the counter on chip-select release breaks the very next header. The reference model predicts every MISO byte from its own copy of both spaces, so each of these faults is caught at the first byte it touches.

// File: rtl/spi_regfile.sv
module spi_regfile #(
  parameter int DIR_AW   = 6,
  parameter int IND_AW   = 8,
  parameter int WIN_ADDR = 62
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sck,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic spi_miso_oe
);
  localparam int DIR_N = 1 << DIR_AW;
  localparam int IND_N = 1 << IND_AW;
  localparam logic [DIR_AW-1:0] WIN = DIR_AW'(WIN_ADDR);

  typedef enum logic [1:0] {PH_HDR, PH_IDX, PH_DATA, PH_SKIP} phase_t;

  logic [2:0] sck_q;
  logic [1:0] cs_q, mosi_q;
  logic [2:0] bit_cnt;
  logic [6:0] rx_sr;
  logic [7:0] tx_sr, tx_hold, tx_next;
  logic       ld_pend, rd_q, ind_q;
  phase_t     phase;
  logic [DIR_AW-1:0] dptr;
  logic [IND_AW-1:0] iptr;
  logic [DIR_N-1:0][7:0] dmem;
  logic [IND_N-1:0][7:0] imem;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= '0;
      cs_q   <= 2'b11;
      mosi_q <= '0;
    end else begin
      sck_q  <= {sck_q[1:0], spi_sck};
      cs_q   <= {cs_q[0], spi_cs_n};
      mosi_q <= {mosi_q[0], spi_mosi};
    end
  end

  wire sck_rise = sck_q[1] & ~sck_q[2];
  wire sck_fall = ~sck_q[1] & sck_q[2];
  wire cs_act   = ~cs_q[1];
  wire [7:0] rx_byte  = {rx_sr, mosi_q[1]};
  wire byte_done      = cs_act & sck_rise & (bit_cnt == 3'd7);
  wire hdr_rd         = rx_byte[7];
  wire hdr_buf        = rx_byte[6];
  wire [DIR_AW-1:0] hdr_addr = rx_byte[DIR_AW-1:0];
  wire [DIR_AW-1:0] dptr_nx  = dptr + 1'b1;
  wire [IND_AW-1:0] iptr_nx  = iptr + 1'b1;

  wire data_wr   = byte_done & (phase == PH_DATA) & ~rd_q;
  wire wr_dir_en = data_wr & ~ind_q & (dptr != WIN);
  wire wr_ind_en = data_wr & ind_q;

  always_comb begin
    tx_next = 8'h00;
    case (phase)
      PH_HDR:  if (hdr_rd && !hdr_buf && hdr_addr != WIN) tx_next = dmem[hdr_addr];
      PH_IDX:  if (rd_q) tx_next = imem[rx_byte[IND_AW-1:0]];
      PH_DATA: if (rd_q) tx_next = ind_q ? imem[iptr_nx] : dmem[dptr_nx];
      default: tx_next = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      rx_sr   <= '0;
      tx_sr   <= '0;
      tx_hold <= '0;
      ld_pend <= 1'b0;
      rd_q    <= 1'b0;
      ind_q   <= 1'b0;
      phase   <= PH_HDR;
      dptr    <= '0;
      iptr    <= '0;
    end else if (!cs_act) begin
      bit_cnt <= '0;
      tx_sr   <= '0;
      ld_pend <= 1'b0;
      rd_q    <= 1'b0;
      phase   <= PH_HDR;
    end else begin
      if (sck_rise) begin
        bit_cnt <= bit_cnt + 3'd1;
        rx_sr   <= rx_byte[6:0];
      end
      if (byte_done) begin
        tx_hold <= tx_next;
        ld_pend <= 1'b1;
        case (phase)
          PH_HDR: begin
            rd_q <= hdr_rd;
            if (hdr_buf) phase <= PH_SKIP;
            else if (hdr_addr == WIN) begin
              phase <= PH_IDX;
              ind_q <= 1'b1;
            end else begin
              phase <= PH_DATA;
              ind_q <= 1'b0;
              dptr  <= hdr_addr;
            end
          end
          PH_IDX: begin
            iptr  <= rx_byte[IND_AW-1:0];
            phase <= PH_DATA;
          end
          PH_DATA: begin
            if (ind_q) iptr <= iptr_nx;
            else dptr <= dptr_nx;
          end
          default: ;
        endcase
      end
      if (sck_fall) begin
        if (ld_pend) begin
          tx_sr   <= tx_hold;
          ld_pend <= 1'b0;
        end else begin
          tx_sr <= {tx_sr[6:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dmem <= '0;
      imem <= '0;
    end else begin
      if (wr_dir_en) dmem[dptr] <= rx_byte;
      if (wr_ind_en) imem[iptr] <= rx_byte;
    end
  end

  assign spi_miso_oe = ~spi_cs_n;
  assign spi_miso    = spi_miso_oe & tx_sr[7];
endmodule

// File: rtl/spi_regfile_chk.sv
module spi_regfile_chk #(
  parameter int DIR_AW   = 6,
  parameter int IND_AW   = 8,
  parameter int VER_ADDR = 59
) (
  input logic clk,
  input logic rst_n,
  input logic cs_act,
  input logic [2:0] bit_cnt,
  input logic [1:0] phase,
  input logic wr_dir_en,
  input logic wr_ind_en,
  input logic [DIR_AW-1:0] dptr,
  input logic [IND_AW-1:0] iptr,
  input logic [(1<<DIR_AW)-1:0][7:0] dmem,
  input logic [(1<<IND_AW)-1:0][7:0] imem
);
  localparam logic [DIR_AW-1:0] VER = DIR_AW'(VER_ADDR);
  localparam logic [1:0] SKIP = 2'd3;

  p_bitcnt_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> bit_cnt == 3'd0);

  p_idle_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |-> !(wr_dir_en || wr_ind_en));

  p_single_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_dir_en, wr_ind_en}));

  p_skip_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == SKIP) |=> ($stable(dmem) && $stable(imem)));

  p_ver_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_dir_en && dptr == VER) |=> $stable(dmem[VER]));

  p_ind_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ind_en |=> iptr == IND_AW'($past(iptr) + 1'b1));
endmodule

bind spi_regfile spi_regfile_chk #(.DIR_AW(DIR_AW), .IND_AW(IND_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .bit_cnt(bit_cnt), .phase(phase),
  .wr_dir_en(wr_dir_en), .wr_ind_en(wr_ind_en), .dptr(dptr), .iptr(iptr),
  .dmem(dmem), .imem(imem)
);

// File: tb/spi_regfile_tb.sv
module spi_regfile_tb;
  localparam int CLK_P = 10;
  localparam int HALF  = 6;

  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  wire  miso, oe;
  int   checks = 0, errors = 0, cyc = 0;
  logic [7:0] ref_dir [64];
  logic [7:0] ref_ind [256];
  logic [7:0] mo_q[$];
  logic [7:0] ex_q[$];

  always #(CLK_P/2) clk = ~clk;

  spi_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(miso), .spi_miso_oe(oe)
  );

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog R9: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  // R10: output enable follows chip select, checked every clock
  always @(posedge clk) begin
    #(CLK_P/4);
    if (rst_n) begin
      checks++;
      if (oe !== !cs_n) begin
        errors++;
        $display("FAIL R10 miso_oe: actual=%b expected=%b", oe, !cs_n);
      end
    end
  end

  task automatic model();
    logic [7:0] hdr;
    ex_q.delete();
    hdr = mo_q[0];
    ex_q.push_back(8'h00);
    for (int k = 1; k < mo_q.size(); k++) begin
      if (hdr[6]) ex_q.push_back(8'h00);
      else if (hdr[5:0] == 6'h3E) begin
        if (k == 1) ex_q.push_back(8'h00);
        else begin
          logic [7:0] loc;
          loc = 8'(int'(mo_q[1]) + k - 2);
          if (hdr[7]) ex_q.push_back(ref_ind[loc]);
          else begin
            ref_ind[loc] = mo_q[k];
            ex_q.push_back(8'h00);
          end
        end
      end else begin
        logic [5:0] loc6;
        loc6 = 6'(int'(hdr[5:0]) + k - 1);
        if (hdr[7]) ex_q.push_back(ref_dir[loc6]);
        else begin
          if (loc6 != 6'h3E) ref_dir[loc6] = mo_q[k];
          ex_q.push_back(8'h00);
        end
      end
    end
  endtask

  task automatic shift_bits(input logic [7:0] b, input int n, output logic [7:0] got);
    got = 8'h00;
    for (int i = 0; i < n; i++) begin
      mosi = b[7-i];
      repeat (HALF) @(negedge clk);
      got = {got[6:0], miso};
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic xfer(input string req, input int tail_bits);
    logic [7:0] got;
    model();
    @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < mo_q.size(); i++) begin
      shift_bits(mo_q[i], 8, got);
      checks++;
      if (got !== ex_q[i]) begin
        errors++;
        $display("FAIL %s byte %0d: actual=%02h expected=%02h", req, i, got, ex_q[i]);
      end
    end
    if (tail_bits > 0) shift_bits(8'h5A, tail_bits, got);
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (2*HALF) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) ref_dir[i] = 8'h00;
    for (int i = 0; i < 256; i++) ref_ind[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset contents, whole direct space and part of indirect space
    mo_q = '{8'h80};
    for (int i = 0; i < 64; i++) mo_q.push_back(8'h00);
    xfer("R1 direct reset", 0);
    mo_q = '{8'hBE, 8'h00};
    for (int i = 0; i < 16; i++) mo_q.push_back(8'h00);
    xfer("R1 indirect reset", 0);

    // R2 / R3: single write and read back
    mo_q = '{8'h05, 8'hA5}; xfer("R2 write", 0);
    mo_q = '{8'h85, 8'h00}; xfer("R3 read", 0);
    mo_q = '{8'h12, 8'h3C}; xfer("R2 write", 0);
    mo_q = '{8'h92, 8'hFF}; xfer("R3 read", 0);

    // R11: version slot keeps the latest value
    mo_q = '{8'h3B, 8'h0C}; xfer("R11 write", 0);
    mo_q = '{8'hBB, 8'h00}; xfer("R11 read", 0);
    mo_q = '{8'h3B, 8'h17}; xfer("R11 rewrite", 0);
    mo_q = '{8'hBB, 8'h00}; xfer("R11 reread", 0);

    // R4: direct burst across window and wrap
    mo_q = '{8'h3C, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55}; xfer("R4 burst write", 0);
    mo_q = '{8'hBC, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}; xfer("R4 burst read", 0);

    // R5 / R6: indirect single access
    mo_q = '{8'h3E, 8'h31, 8'h02}; xfer("R5 write", 0);
    mo_q = '{8'hBE, 8'h31, 8'h00}; xfer("R6 read", 0);
    mo_q = '{8'h3E, 8'h91, 8'hB3}; xfer("R5 write", 0);
    mo_q = '{8'hBE, 8'h90, 8'h00, 8'h00, 8'h00}; xfer("R6 read", 0);

    // R7: indirect burst wrap
    mo_q = '{8'h3E, 8'hFE, 8'hC1, 8'hC2, 8'hC3}; xfer("R7 burst write", 0);
    mo_q = '{8'hBE, 8'hFD, 8'h00, 8'h00, 8'h00, 8'h00}; xfer("R7 burst read", 0);

    // R8: buffer-select headers touch nothing
    mo_q = '{8'h45, 8'hFF, 8'hEE}; xfer("R8 write", 0);
    mo_q = '{8'hC5, 8'h00, 8'h00}; xfer("R8 read", 0);
    mo_q = '{8'h85, 8'h00}; xfer("R8 readback", 0);

    // R9: aborted transfers
    mo_q = '{8'h07}; xfer("R9 partial data", 4);
    mo_q = '{8'h87, 8'h00}; xfer("R9 readback", 0);
    mo_q = '{8'h3E, 8'h31, 8'h7E}; xfer("R9 burst cut", 5);
    mo_q = '{8'hBE, 8'h31, 8'h00, 8'h00}; xfer("R9 readback", 0);
    mo_q.delete(); mo_q.push_back(8'h00);
    begin
      logic [7:0] dummy;
      @(negedge clk); cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
      shift_bits(8'h85, 3, dummy);
      repeat (HALF) @(negedge clk); cs_n = 1'b1;
      repeat (2*HALF) @(negedge clk);
    end
    mo_q = '{8'h85, 8'h00}; xfer("R9 fresh header", 0);

    summary();
    $finish;
  end
endmodule